// File: doc/BRIEF.md
# Real-Time Clock with Byte Register Interface

The block keeps time of day and weekday from a single-cycle tick strobe, which either comes from a 32768 Hz crystal or from a rectified 50 Hz or 60 Hz mains signal. A prescaler counts these strobes and raises a one-cycle step once per second. Each step advances the seconds, minutes, hours and weekday fields. Every carry settles within that same step. The fields count in plain binary or in packed BCD.

Software reaches the block through a byte-wide register port with sixteen addresses. A control byte selects the clock source, the mains frequency, the number encoding and the interrupt enable. The same byte has an unlock bit, which freezes the prescaler and lets the time fields be loaded. A single alarm compares the hours, minutes and seconds against three alarm bytes, and each of those three fields can be enabled on its own. A match raises a sticky flag and, when enabled, an interrupt. If the match happens while the device is asleep, it also raises a wake flag. Reading the control byte clears both flags.

The prescaler is a two-state machine. ST_COUNT divides the ticks, and it is the state after reset. ST_HALT holds the divide count at zero while the unlock bit is set. There are two transitions: COUNT to HALT when unlock is set, and HALT to COUNT when unlock is cleared. Because of this, the first second after a relock takes a full divide period.

Top module: `rtc_core`

## Requirements
- R1: After reset, the control byte (address 0) reads 0x00. Time reads 00:00:00 with weekday 1. `osc_en_o` is 1 and `irq_o` is 0.
- R2: When control bit 4 is 0 (crystal source), the seconds field advances on exactly the XTAL_DIV-th tick after the previous step.
- R3: When control bit 4 is 1 (mains source), a second takes LINE60_DIV ticks if control bit 3 is 0 and LINE50_DIV ticks if control bit 3 is 1. `osc_en_o` equals the inverse of bit 4.
- R4: With control bit 5 at 0 (binary), seconds (address 1) and minutes (address 2) wrap from 59 to 0, hours (address 3) wrap from 23 to 0, and weekday (address 4) wraps from 7 to 1. Each carry lands in the same step.
- R5: With control bit 5 at 1, the same fields count in packed BCD (high nibble tens, low nibble units): 0x59 to 0x00, 0x23 to 0x00, 0x09 to 0x10.
- R6: While control bit 0 (unlock) is 0, writes to addresses 1 to 4 leave the fields unchanged.
- R7: While unlock is 1, the fields accept writes and never advance. Clearing unlock restarts the divide count from zero.
- R8: The alarm fires on a step whose new hours, minutes and seconds equal addresses 7, 6 and 5 in every field that is enabled in address 8 (bit 0 seconds, bit 1 minutes, bit 2 hours). With no field enabled it never fires.
- R9: An alarm sets control bit 7. `irq_o` is high only while bit 7 and control bit 6 are both 1.
- R10: A read of address 0 returns the flags as they were, then clears bits 7 and 1. An alarm in the same cycle as the read leaves bit 7 set.
- R11: An alarm while `sleep_i` is 1 sets control bit 1 and `wake_o`.
- R12: Control bit 2 is read/write storage that has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe per source clock edge |
| sleep_i | input | 1 | High while the device is in sleep mode |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears flags when the address is 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Sleep recovery flag |
| osc_en_o | output | 1 | Crystal oscillator enable |

## Verification
The assertions assume the three divide parameters are each at least 2, so two steps can never fall on adjacent cycles. They also assume the time fields change only through a step or a bus write. The stimulus keeps the tick low for at least one cycle between strobes. It loads only legal values in the chosen encoding, and it changes the source or the frequency only right after a step, when the divide count is zero. Expected times are derived from a count of elapsed seconds taken modulo the field ranges. That count covers rollovers of the minute, the hour, the day and the week in both encodings.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_FIELDS = 4;

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_SEC  = 4'd1;
    localparam logic [3:0] A_MIN  = 4'd2;
    localparam logic [3:0] A_HR   = 4'd3;
    localparam logic [3:0] A_DOW  = 4'd4;
    localparam logic [3:0] A_ASEC = 4'd5;
    localparam logic [3:0] A_AMIN = 4'd6;
    localparam logic [3:0] A_AHR  = 4'd7;
    localparam logic [3:0] A_AEN  = 4'd8;

    typedef enum logic {ST_HALT = 1'b0, ST_COUNT = 1'b1} pre_state_e;

    function automatic logic [7:0] field_max(int idx);
        case (idx)
            2:       return 8'd23;
            3:       return 8'd7;
            default: return 8'd59;
        endcase
    endfunction

    function automatic logic [7:0] field_min(int idx);
        return (idx == 3) ? 8'd1 : 8'd0;
    endfunction

    function automatic logic [7:0] to_bcd(logic [7:0] v);
        logic [7:0] tens;
        logic [7:0] units;
        tens  = v / 8'd10;
        units = v % 8'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    // returns {carry, next value}
    function automatic logic [8:0] step_field(logic [7:0] v, logic [7:0] maxbin,
                                              logic [7:0] minv, logic bcd);
        logic [7:0] top;
        top = bcd ? to_bcd(maxbin) : maxbin;
        if (v == top)
            return {1'b1, minv};
        if (bcd && v[3:0] == 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        return {1'b0, v + 8'd1};
    endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale
    import rtc_pkg::*;
#(
    parameter int XTAL_DIV   = 32768,
    parameter int LINE60_DIV = 60,
    parameter int LINE50_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic unlock_i,
    input  logic src_line_i,
    input  logic freq50_i,
    output logic sec_pulse_o
);

    localparam int MAX_A  = (XTAL_DIV > LINE60_DIV) ? XTAL_DIV : LINE60_DIV;
    localparam int MAXDIV = (MAX_A > LINE50_DIV) ? MAX_A : LINE50_DIV;
    localparam int CW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;

    localparam logic [CW-1:0] XTAL_M1 = CW'(XTAL_DIV - 1);
    localparam logic [CW-1:0] L60_M1  = CW'(LINE60_DIV - 1);
    localparam logic [CW-1:0] L50_M1  = CW'(LINE50_DIV - 1);

    pre_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   lim_m1;
    logic            wrap;

    always_comb begin
        if (src_line_i)
            lim_m1 = freq50_i ? L50_M1 : L60_M1;
        else
            lim_m1 = XTAL_M1;
    end

    assign wrap = (cnt_q >= lim_m1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_COUNT;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: if (unlock_i)  state_d = ST_HALT;
            ST_HALT:  if (!unlock_i) state_d = ST_COUNT;
            default:  state_d = ST_HALT;
        endcase
    end

    // divide count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (state_q == ST_HALT)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        sec_pulse_o = 1'b0;
        unique case (state_q)
            ST_COUNT: sec_pulse_o = tick_i && wrap && !unlock_i;
            ST_HALT:  sec_pulse_o = 1'b0;
            default:  sec_pulse_o = 1'b0;
        endcase
    end

    p_pulse_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse_o |=> !sec_pulse_o);

    p_relock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_i |=> !sec_pulse_o);

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_i,
    input  logic        bcd_i,
    input  logic        wr_i,
    input  logic [1:0]  wr_sel_i,
    input  logic [7:0]  wr_data_i,
    output logic [31:0] time_o,     // {dow, hr, min, sec}
    output logic [23:0] nxt_hms_o   // {hr, min, sec} after this step
);

    logic [7:0] fld_q [NUM_FIELDS];
    logic [7:0] fld_d [NUM_FIELDS];

    always_comb begin
        logic       carry;
        logic [8:0] inc;
        carry = step_i;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            inc      = step_field(fld_q[i], field_max(i), field_min(i), bcd_i);
            fld_d[i] = carry ? inc[7:0] : fld_q[i];
            carry    = carry & inc[8];
        end
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        always_ff @(posedge clk) begin
            if (!rst_n)
                fld_q[g] <= field_min(g);
            else if (wr_i && wr_sel_i == 2'(g))
                fld_q[g] <= wr_data_i;
            else
                fld_q[g] <= fld_d[g];
        end
    end

    assign time_o    = {fld_q[3], fld_q[2], fld_q[1], fld_q[0]};
    assign nxt_hms_o = {fld_d[2], fld_d[1], fld_d[0]};

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !wr_i) |=> $stable(time_o));

    p_wr_not_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> !step_i);

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_i,
    input  logic [23:0] nxt_hms_i,
    input  logic [7:0]  asec_i,
    input  logic [7:0]  amin_i,
    input  logic [7:0]  ahr_i,
    input  logic [2:0]  aen_i,
    input  logic        rd_clr_i,
    input  logic        sleep_i,
    output logic        match_o,
    output logic        flag_o,
    output logic        wake_o
);

    logic sec_ok, min_ok, hr_ok;

    assign sec_ok  = !aen_i[0] || (nxt_hms_i[7:0]   == asec_i);
    assign min_ok  = !aen_i[1] || (nxt_hms_i[15:8]  == amin_i);
    assign hr_ok   = !aen_i[2] || (nxt_hms_i[23:16] == ahr_i);
    assign match_o = step_i && (|aen_i) && sec_ok && min_ok && hr_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            if (match_o)
                flag_o <= 1'b1;
            else if (rd_clr_i)
                flag_o <= 1'b0;
            if (match_o && sleep_i)
                wake_o <= 1'b1;
            else if (rd_clr_i)
                wake_o <= 1'b0;
        end
    end

    p_clear_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !match_o) |=> (!flag_o && !wake_o));

    p_set_on_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> flag_o);

    p_no_field_no_alarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (aen_i == 3'b000) |-> !match_o);

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int XTAL_DIV   = 32768,
    parameter int LINE60_DIV = 60,
    parameter int LINE50_DIV = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       sleep_i,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_o,
    output logic       wake_o,
    output logic       osc_en_o
);

    logic        ien_q, bcd_q, src_q, frq_q, dst_q, unl_q;
    logic [7:0]  asec_q, amin_q, ahr_q;
    logic [2:0]  aen_q;
    logic        step;
    logic        cnt_wr;
    logic [1:0]  cnt_sel;
    logic [31:0] time_now;
    logic [23:0] nxt_hms;
    logic        rd_clr, match, flag;
    logic [3:0]  sel_off;

    // control and alarm registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ien_q, bcd_q, src_q, frq_q, dst_q, unl_q} <= '0;
            asec_q <= '0;
            amin_q <= '0;
            ahr_q  <= '0;
            aen_q  <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_CTRL: begin
                    ien_q <= bus_wdata[6];
                    bcd_q <= bus_wdata[5];
                    src_q <= bus_wdata[4];
                    frq_q <= bus_wdata[3];
                    dst_q <= bus_wdata[2];
                    unl_q <= bus_wdata[0];
                end
                A_ASEC:  asec_q <= bus_wdata;
                A_AMIN:  amin_q <= bus_wdata;
                A_AHR:   ahr_q  <= bus_wdata;
                A_AEN:   aen_q  <= bus_wdata[2:0];
                default: ;
            endcase
        end
    end

    assign sel_off = bus_addr - A_SEC;
    assign cnt_sel = sel_off[1:0];
    assign cnt_wr  = bus_wr && unl_q && (bus_addr >= A_SEC) && (bus_addr <= A_DOW);
    assign rd_clr  = bus_rd && (bus_addr == A_CTRL);

    rtc_prescale #(
        .XTAL_DIV   (XTAL_DIV),
        .LINE60_DIV (LINE60_DIV),
        .LINE50_DIV (LINE50_DIV)
    ) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .unlock_i    (unl_q),
        .src_line_i  (src_q),
        .freq50_i    (frq_q),
        .sec_pulse_o (step)
    );

    rtc_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .bcd_i     (bcd_q),
        .wr_i      (cnt_wr),
        .wr_sel_i  (cnt_sel),
        .wr_data_i (bus_wdata),
        .time_o    (time_now),
        .nxt_hms_o (nxt_hms)
    );

    rtc_alarm u_alm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .nxt_hms_i (nxt_hms),
        .asec_i    (asec_q),
        .amin_i    (amin_q),
        .ahr_i     (ahr_q),
        .aen_i     (aen_q),
        .rd_clr_i  (rd_clr),
        .sleep_i   (sleep_i),
        .match_o   (match),
        .flag_o    (flag),
        .wake_o    (wake_o)
    );

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {flag, ien_q, bcd_q, src_q, frq_q, dst_q, wake_o, unl_q};
            A_SEC:   bus_rdata = time_now[7:0];
            A_MIN:   bus_rdata = time_now[15:8];
            A_HR:    bus_rdata = time_now[23:16];
            A_DOW:   bus_rdata = time_now[31:24];
            A_ASEC:  bus_rdata = asec_q;
            A_AMIN:  bus_rdata = amin_q;
            A_AHR:   bus_rdata = ahr_q;
            A_AEN:   bus_rdata = {5'b0, aen_q};
            default: bus_rdata = 8'h00;
        endcase
    end

    assign irq_o    = flag & ien_q;
    assign osc_en_o = ~src_q;

    p_halt_no_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        unl_q |-> !step);

    p_irq_follows_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (match && ien_q && !(bus_wr && bus_addr == A_CTRL)) |=> irq_o);

endmodule

// File: tb/sim_rtc_core.sv
module sim_rtc_core;

    localparam int CLK_PERIOD = 10;
    localparam int XD  = 8;
    localparam int L60 = 6;
    localparam int L50 = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_o, wake_o, osc_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_core #(.XTAL_DIV(XD), .LINE60_DIV(L60), .LINE50_DIV(L50)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sleep_i(sleep_i),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wake_o(wake_o), .osc_en_o(osc_en_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic run_sec(input int n);
        repeat (n * XD) tick();
    endtask

    function automatic int enc(input int x, input bit bcd);
        return bcd ? ((x / 10) * 16 + (x % 10)) : x;
    endfunction

    task automatic load_time(input int h, input int m, input int s, input int d, input bit bcd);
        wr(4'd1, 8'(enc(s, bcd)));
        wr(4'd2, 8'(enc(m, bcd)));
        wr(4'd3, 8'(enc(h, bcd)));
        wr(4'd4, 8'(d));
    endtask

    task automatic check_time(input string tag, input int tot, input int d0, input bit bcd);
        logic [7:0] v;
        rd(4'd1, v); check({tag, " sec"}, v, enc(tot % 60, bcd));
        rd(4'd2, v); check({tag, " min"}, v, enc((tot / 60) % 60, bcd));
        rd(4'd3, v); check({tag, " hr"},  v, enc((tot / 3600) % 24, bcd));
        rd(4'd4, v); check({tag, " dow"}, v, ((d0 - 1 + tot / 86400) % 7) + 1);
    endtask

    task automatic sweep(input string tag, input bit bcd, input int h, input int m,
                         input int s, input int d, input int nsec);
        int start;
        start = h * 3600 + m * 60 + s;
        wr(4'd0, bcd ? 8'h21 : 8'h01);
        load_time(h, m, s, d, bcd);
        wr(4'd0, bcd ? 8'h20 : 8'h00);
        for (int k = 1; k <= nsec; k++) begin
            run_sec(1);
            check_time(tag, start + k, d, bcd);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        logic [7:0] s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, v); check("R1 ctrl", v, 8'h00);
        check_time("R1 time", 0, 1, 1'b0);
        check("R1 osc_en", osc_en_o, 1);
        check("R1 irq", irq_o, 0);

        // R6 locked writes ignored
        wr(4'd1, 8'd5); wr(4'd3, 8'd9);
        check_time("R6 locked", 0, 1, 1'b0);

        // R7 halted while unlocked
        wr(4'd0, 8'h01);
        load_time(23, 59, 58, 7, 1'b0);
        run_sec(3);
        check_time("R7 halted", 23 * 3600 + 59 * 60 + 58, 7, 1'b0);

        // R2 exact divide
        wr(4'd0, 8'h00);
        repeat (XD - 1) tick();
        rd(4'd1, v); check("R2 before edge", v, 58);
        tick();
        rd(4'd1, v); check("R2 on edge", v, 59);

        // R7 prescaler restart after relock
        repeat (3) tick();
        wr(4'd0, 8'h01); wr(4'd0, 8'h00);
        repeat (XD - 1) tick();
        rd(4'd1, v); check("R7 restart", v, 59);
        tick();
        check_time("R4 day wrap", 86400, 7, 1'b0);

        // R4 / R5 sweeps
        sweep("R4 bin", 1'b0, 23, 58, 50, 7, 80);
        sweep("R4 bin hour", 1'b0, 12, 59, 58, 2, 5);
        sweep("R5 bcd", 1'b1, 23, 58, 50, 7, 80);
        sweep("R5 bcd nibble", 1'b1, 9, 59, 55, 3, 10);

        // R3 mains source
        wr(4'd0, 8'h10);
        check("R3 osc_en off", osc_en_o, 0);
        rd(4'd1, s0);
        repeat (L60 - 1) tick();
        rd(4'd1, v); check("R3 60 early", v, s0);
        tick();
        rd(4'd1, v); check("R3 60 edge", v, s0 + 8'h01);
        wr(4'd0, 8'h18);
        rd(4'd1, s0);
        repeat (L50 - 1) tick();
        rd(4'd1, v); check("R3 50 early", v, s0);
        tick();
        rd(4'd1, v); check("R3 50 edge", v, s0 + 8'h01);
        wr(4'd0, 8'h00);
        check("R3 osc_en on", osc_en_o, 1);

        // R8 / R9 alarm with interrupt
        wr(4'd0, 8'h01);
        load_time(0, 0, 0, 1, 1'b0);
        wr(4'd5, 8'd3); wr(4'd6, 8'd0); wr(4'd7, 8'd0); wr(4'd8, 8'h07);
        wr(4'd0, 8'h40);
        run_sec(2);
        check("R8 no early alarm", irq_o, 0);
        run_sec(1);
        check("R9 irq raised", irq_o, 1);
        rd(4'd0, v); check("R10 read flags", v, 8'hC0);
        check("R10 irq cleared", irq_o, 0);
        rd(4'd0, v); check("R10 second read", v, 8'h40);

        // R9 interrupt gated off
        wr(4'd0, 8'h00);
        wr(4'd5, 8'd5);
        run_sec(2);
        check("R9 irq gated", irq_o, 0);
        rd(4'd0, v); check("R9 flag only", v, 8'h80);

        // R8 no field enabled
        wr(4'd8, 8'h00); wr(4'd5, 8'd6);
        run_sec(1);
        rd(4'd0, v); check("R8 none enabled", v, 8'h00);

        // R8 seconds-only enable ignores minutes
        wr(4'd8, 8'h01); wr(4'd5, 8'd8); wr(4'd6, 8'd9);
        run_sec(2);
        rd(4'd0, v); check("R8 partial enable", v, 8'h80);

        // R10 alarm in the cycle of the read
        wr(4'd5, 8'd9);
        repeat (XD - 1) tick();
        @(negedge clk);
        tick_i = 1'b1; bus_addr = 4'd0; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        tick_i = 1'b0; bus_rd = 1'b0;
        check("R10 pre value", v, 8'h00);
        rd(4'd0, v); check("R10 alarm wins", v, 8'h80);

        // R11 wake during sleep
        sleep_i = 1'b1;
        wr(4'd5, 8'd10);
        run_sec(1);
        sleep_i = 1'b0;
        check("R11 wake_o", wake_o, 1);
        rd(4'd0, v); check("R11 wake bit", v, 8'h82);
        check("R11 wake cleared", wake_o, 0);

        // R12 storage bit
        wr(4'd0, 8'h04);
        rd(4'd0, v); check("R12 dst readback", v, 8'h04);
        run_sec(1);
        rd(4'd1, v); check("R12 counting unaffected", v, 11);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule